// File: doc/BRIEF.md
# GPIO Edge Interrupt Generator

This block turns level changes on a 32-pin GPIO register set into interrupt status and interrupt lines. It compares each synchronized pin level with its value one clock earlier. A low-to-high change is a rising edge and a high-to-low change is a falling edge. When the matching per-pin trigger enable is on, the edge latches a status bit. Software clears that bit by writing a one to it. Rising and falling triggers are separate enable vectors, and each is changed only through its own set port and its own clear port. Edges are seen whatever the pin's direction, so a pin driven as an output can raise interrupts on itself.

The status word is split into 16-bit halves. Each half drives its own bank interrupt line, gated by one bit of a bank enable register. Bits 15:0 form the even bank and bits 31:16 form the odd bank. When `DIRECT_MODE` is set, the first `DIRECT_N` pins also each drive a private interrupt line. That line pulses for one clock on every enabled edge. Across several register sets, a status bit maps to global pin `(bank/2)*32 + bit`. Bus decoding and the pin synchronizers live outside this block.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset, `rise_en`, `fall_en`, `irq_stat` and `bank_en` are all zero, and `bank_irq` and `pin_irq` are low.
- R2: A cycle with `rise_set_wr` high sets every `rise_en` bit where `wr_data` is 1. A cycle with `rise_clr_wr` high clears every `rise_en` bit where `wr_data` is 1. Bits where `wr_data` is 0 keep their value. If both strobes hit the same bit in one cycle, the clear wins.
- R3: `fall_en` follows the same set/clear rules through `fall_set_wr` and `fall_clr_wr`.
- R4: A 0-to-1 change on `pin_lvl[i]` sets `irq_stat[i]` at the next rising clock edge, but only if `rise_en[i]` is 1. A change with no matching enable leaves `irq_stat` unchanged.
- R5: With both `rise_en[i]` and `fall_en[i]` at 1, either direction of change on `pin_lvl[i]` sets `irq_stat[i]`.
- R6: A cycle with `stat_clr_wr` high clears each `irq_stat` bit where `wr_data` is 1. Bits written with 0 are not affected.
- R7: If an enabled edge on pin i occurs in the same cycle that a clear of bit i is written, `irq_stat[i]` stays 1.
- R8: `bank_irq[n]` is 1 exactly while `bank_en[n]` is 1 and status slice n is nonzero. Slice 0 is bits 15:0 and slice 1 is bits 31:16. A cycle with `bank_en_wr` high loads `bank_en` from `wr_data[1:0]`.
- R9: With `DIRECT_MODE` set, `pin_irq[i]` for i < `DIRECT_N` is high for exactly one cycle, in the cycle where an enabled edge on pin i sets its status. Pins at or above `DIRECT_N` never drive a direct line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_lvl | input | 32 | Synchronized pin levels |
| wr_data | input | 32 | Write data shared by all strobes |
| rise_set_wr | input | 1 | Set rising-edge enables where wr_data is 1 |
| rise_clr_wr | input | 1 | Clear rising-edge enables where wr_data is 1 |
| fall_set_wr | input | 1 | Set falling-edge enables where wr_data is 1 |
| fall_clr_wr | input | 1 | Clear falling-edge enables where wr_data is 1 |
| stat_clr_wr | input | 1 | Write-one-to-clear the status word |
| bank_en_wr | input | 1 | Load bank enables from wr_data[1:0] |
| rise_en | output | 32 | Rising-edge enable vector |
| fall_en | output | 32 | Falling-edge enable vector |
| irq_stat | output | 32 | Latched interrupt status |
| bank_en | output | 2 | Per-bank interrupt enables |
| bank_irq | output | 2 | Bank interrupt lines |
| pin_irq | output | 8 | Direct per-pin interrupt pulses |

## Verification
The assertions assume that `pin_lvl` is already synchronous to `clk`, so any change is a clean single-cycle transition. They also assume that a write strobe and its `wr_data` are valid together for the one cycle they are sampled. The bench changes pins and strobes only on the falling clock edge, with each strobe held high for a single cycle, and it reads results one cycle later. The one deliberate overlap, an edge arriving in the same cycle as a clear, is applied in one falling-edge step so the overlap is exact.

// File: rtl/gpio_eirq_pkg.sv
package gpio_eirq_pkg;
   // Next value of a set/clear register: clear has priority over set.
   function automatic logic [31:0] setclr_next(input logic [31:0] q,
                                               input logic [31:0] set_m,
                                               input logic [31:0] clr_m);
      return (q | set_m) & ~clr_m;
   endfunction
endpackage

// File: rtl/gpio_eirq_setclr.sv
module gpio_eirq_setclr #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_wr,
   input  logic         clr_wr,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);
   import gpio_eirq_pkg::*;
   logic [31:0] set_m, clr_m, nxt;

   always_comb begin
      set_m = '0;
      clr_m = '0;
      if (set_wr) set_m[W-1:0] = wdata;
      if (clr_wr) clr_m[W-1:0] = wdata;
      nxt = setclr_next({{(32-W){1'b0}}, q}, set_m, clr_m);
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) q <= '0;
      else        q <= nxt[W-1:0];
endmodule

// File: rtl/gpio_eirq_edge.sv
module gpio_eirq_edge #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl,
   output logic [W-1:0] rise,
   output logic [W-1:0] fall
);
   logic [W-1:0] lvl_d;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) lvl_d <= '0;
      else        lvl_d <= lvl;

   assign rise = lvl & ~lvl_d;
   assign fall = ~lvl & lvl_d;
endmodule

// File: rtl/gpio_eirq_status.sv
module gpio_eirq_status #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] hit,
   input  logic         clr_wr,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);
   logic [W-1:0] clr_m;
   assign clr_m = clr_wr ? wdata : '0;

   // A new hit overrides a clear in the same cycle.
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) q <= '0;
      else        q <= (q & ~clr_m) | hit;
endmodule

// File: rtl/gpio_eirq_bank.sv
module gpio_eirq_bank #(
   parameter int W      = 32,
   parameter int HALF_W = 16,
   localparam int NBANK = W / HALF_W
) (
   input  logic [W-1:0]     stat,
   input  logic [NBANK-1:0] en,
   output logic [NBANK-1:0] irq
);
   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      assign irq[b] = en[b] & (|stat[b*HALF_W +: HALF_W]);
   end
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
   parameter int PIN_W       = 32,
   parameter int HALF_W      = 16,
   parameter bit DIRECT_MODE = 1'b1,
   parameter int DIRECT_N    = 8,
   localparam int NBANK      = PIN_W / HALF_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [PIN_W-1:0]    pin_lvl,
   input  logic [PIN_W-1:0]    wr_data,
   input  logic                rise_set_wr,
   input  logic                rise_clr_wr,
   input  logic                fall_set_wr,
   input  logic                fall_clr_wr,
   input  logic                stat_clr_wr,
   input  logic                bank_en_wr,
   output logic [PIN_W-1:0]    rise_en,
   output logic [PIN_W-1:0]    fall_en,
   output logic [PIN_W-1:0]    irq_stat,
   output logic [NBANK-1:0]    bank_en,
   output logic [NBANK-1:0]    bank_irq,
   output logic [DIRECT_N-1:0] pin_irq
);
   if (PIN_W > 32 || PIN_W % HALF_W != 0) begin : g_bad_w
      $error("PIN_W must be a multiple of HALF_W and at most 32");
   end
   if (DIRECT_N < 1 || DIRECT_N > PIN_W) begin : g_bad_n
      $error("DIRECT_N must lie in 1..PIN_W");
   end

   logic [PIN_W-1:0] rise, fall, hit;

   gpio_eirq_edge #(.W(PIN_W)) u_edge (
      .clk(clk), .rst_n(rst_n), .lvl(pin_lvl), .rise(rise), .fall(fall));

   gpio_eirq_setclr #(.W(PIN_W)) u_rise_en (
      .clk(clk), .rst_n(rst_n), .set_wr(rise_set_wr), .clr_wr(rise_clr_wr),
      .wdata(wr_data), .q(rise_en));

   gpio_eirq_setclr #(.W(PIN_W)) u_fall_en (
      .clk(clk), .rst_n(rst_n), .set_wr(fall_set_wr), .clr_wr(fall_clr_wr),
      .wdata(wr_data), .q(fall_en));

   assign hit = (rise & rise_en) | (fall & fall_en);

   gpio_eirq_status #(.W(PIN_W)) u_stat (
      .clk(clk), .rst_n(rst_n), .hit(hit), .clr_wr(stat_clr_wr),
      .wdata(wr_data), .q(irq_stat));

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)          bank_en <= '0;
      else if (bank_en_wr) bank_en <= wr_data[NBANK-1:0];

   gpio_eirq_bank #(.W(PIN_W), .HALF_W(HALF_W)) u_bank (
      .stat(irq_stat), .en(bank_en), .irq(bank_irq));

   if (DIRECT_MODE) begin : g_direct
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n) pin_irq <= '0;
         else        pin_irq <= hit[DIRECT_N-1:0];
   end else begin : g_no_direct
      assign pin_irq = '0;
   end
endmodule

// File: rtl/gpio_edge_irq_chk.sv
module gpio_edge_irq_chk #(
   parameter int PIN_W    = 32,
   parameter int HALF_W   = 16,
   parameter int DIRECT_N = 8,
   localparam int NBANK   = PIN_W / HALF_W
) (
   input logic                clk,
   input logic                rst_n,
   input logic [PIN_W-1:0]    wr_data,
   input logic                rise_set_wr,
   input logic                stat_clr_wr,
   input logic [PIN_W-1:0]    rise_en,
   input logic [PIN_W-1:0]    irq_stat,
   input logic [NBANK-1:0]    bank_en,
   input logic [NBANK-1:0]    bank_irq,
   input logic [DIRECT_N-1:0] pin_irq
);
   logic [PIN_W-1:0] stat_q, clr_q, rise_q, rset_q;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         stat_q <= '0; clr_q <= '0; rise_q <= '0; rset_q <= '0;
      end else begin
         stat_q <= irq_stat;
         clr_q  <= stat_clr_wr ? wr_data : '0;
         rise_q <= rise_en;
         rset_q <= rise_set_wr ? wr_data : '0;
      end

   // R6
   stat_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q & ~irq_stat & ~clr_q) == '0);

   // R2
   rise_en_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_en & ~rise_q & ~rset_q) == '0);

   // R8
   bank_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bank_irq[0] == (bank_en[0] && (irq_stat[HALF_W-1:0] != '0)));

   // R8
   bank_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_irq & ~bank_en) == '0);

   // R9
   direct_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_irq & ~irq_stat[DIRECT_N-1:0]) == '0);
endmodule

bind gpio_edge_irq gpio_edge_irq_chk #(
   .PIN_W(PIN_W), .HALF_W(HALF_W), .DIRECT_N(DIRECT_N)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .rise_set_wr(rise_set_wr),
   .stat_clr_wr(stat_clr_wr), .rise_en(rise_en), .irq_stat(irq_stat),
   .bank_en(bank_en), .bank_irq(bank_irq), .pin_irq(pin_irq));

// File: tb/gpio_edge_irq_test.sv
module gpio_edge_irq_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] pin_lvl = '0;
   logic [31:0] wr_data = '0;
   logic        rise_set_wr = 0, rise_clr_wr = 0, fall_set_wr = 0, fall_clr_wr = 0;
   logic        stat_clr_wr = 0, bank_en_wr = 0;
   logic [31:0] rise_en, fall_en, irq_stat;
   logic [1:0]  bank_en, bank_irq;
   logic [7:0]  pin_irq;
   int          total = 0, bad = 0;
   bit          finished = 0;

   always #5 clk = ~clk;

   gpio_edge_irq uut (
      .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .wr_data(wr_data),
      .rise_set_wr(rise_set_wr), .rise_clr_wr(rise_clr_wr),
      .fall_set_wr(fall_set_wr), .fall_clr_wr(fall_clr_wr),
      .stat_clr_wr(stat_clr_wr), .bank_en_wr(bank_en_wr),
      .rise_en(rise_en), .fall_en(fall_en), .irq_stat(irq_stat),
      .bank_en(bank_en), .bank_irq(bank_irq), .pin_irq(pin_irq));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // One strobe cycle: drive at the falling edge, release at the next one.
   task automatic wr(input logic [5:0] strb, input logic [31:0] d);
      wr_data = d;
      {rise_set_wr, rise_clr_wr, fall_set_wr, fall_clr_wr, stat_clr_wr, bank_en_wr} = strb;
      @(negedge clk);
      {rise_set_wr, rise_clr_wr, fall_set_wr, fall_clr_wr, stat_clr_wr, bank_en_wr} = '0;
      wr_data = '0;
   endtask

   localparam logic [5:0] RS = 6'b100000, RC = 6'b010000, FS = 6'b001000,
                          FC = 6'b000100, SC = 6'b000010, BE = 6'b000001;

   task automatic pins(input logic [31:0] v);
      pin_lvl = v;
      @(negedge clk);
   endtask

   task automatic t_reset;
      chk("R1 rise_en", rise_en, 0);
      chk("R1 fall_en", fall_en, 0);
      chk("R1 irq_stat", irq_stat, 0);
      chk("R1 bank_en", {30'd0, bank_en}, 0);
      chk("R1 lines", {22'd0, bank_irq, pin_irq}, 0);
   endtask

   task automatic t_enables;
      wr(RS, 32'h0000_00F0); chk("R2 set", rise_en, 32'h0000_00F0);
      wr(RS, 32'h0000_0001); chk("R2 zero bits kept", rise_en, 32'h0000_00F1);
      wr(RC, 32'h0000_0010); chk("R2 clear", rise_en, 32'h0000_00E1);
      wr(RS | RC, 32'h0000_0001); chk("R2 clear wins", rise_en, 32'h0000_00E0);
      wr(FS, 32'h8000_0003); chk("R3 set", fall_en, 32'h8000_0003);
      wr(FC, 32'h0000_0002); chk("R3 clear", fall_en, 32'h8000_0001);
      wr(FS | FC, 32'h0000_0004); chk("R3 clear wins", fall_en, 32'h8000_0001);
      chk("R3 rise untouched", rise_en, 32'h0000_00E0);
      wr(RC, 32'hFFFF_FFFF); wr(FC, 32'hFFFF_FFFF);
      chk("R2 all cleared", rise_en | fall_en, 0);
   endtask

   task automatic t_rise;
      wr(RS, 32'h0000_0001);
      wr(BE, 32'h0000_0003);
      chk("R8 bank_en load", {30'd0, bank_en}, 3);
      pins(32'h0000_0001);
      chk("R4 rising sets", irq_stat, 32'h0000_0001);
      chk("R8 bank0 line", {30'd0, bank_irq}, 2'b01);
      chk("R9 direct pulse", {24'd0, pin_irq}, 8'h01);
      @(negedge clk);
      chk("R9 pulse one cycle", {24'd0, pin_irq}, 0);
      pins(32'h0000_0003);
      chk("R4 disabled pin ignored", irq_stat, 32'h0000_0001);
      pins(32'h0000_0000);
      chk("R4 falling ignored without fall_en", irq_stat, 32'h0000_0001);
      chk("R9 no pulse without enable", {24'd0, pin_irq}, 0);
   endtask

   task automatic t_w1c;
      wr(SC, 32'h0000_0000);
      chk("R6 zero write no effect", irq_stat, 32'h0000_0001);
      wr(SC, 32'h0000_0001);
      chk("R6 one clears", irq_stat, 0);
      chk("R8 line drops", {30'd0, bank_irq}, 0);
   endtask

   task automatic t_both;
      wr(FS, 32'h0000_0001);
      pins(32'h0000_0001);
      chk("R5 rising with both", irq_stat, 32'h0000_0001);
      wr(SC, 32'h0000_0001);
      pins(32'h0000_0000);
      chk("R5 falling with both", irq_stat, 32'h0000_0001);
      chk("R9 pulse on fall", {24'd0, pin_irq}, 8'h01);
   endtask

   task automatic t_race;
      // edge and clear of the same bit in one cycle
      pin_lvl = 32'h0000_0001;
      wr(SC, 32'h0000_0001);
      chk("R7 edge beats clear", irq_stat, 32'h0000_0001);
      wr(SC, 32'h0000_0001);
      chk("R6 cleared after race", irq_stat, 0);
   endtask

   task automatic t_bank;
      wr(RS, 32'h0002_0000);
      pins(32'h0002_0001);
      chk("R8 upper slice", irq_stat, 32'h0002_0000);
      chk("R8 bank1 line", {30'd0, bank_irq}, 2'b10);
      chk("R9 no direct line above N", {24'd0, pin_irq}, 0);
      wr(BE, 32'h0000_0001);
      chk("R8 bank1 gated", {30'd0, bank_irq}, 0);
      chk("R8 status kept", irq_stat, 32'h0002_0000);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_enables();
      t_rise();
      t_w1c();
      t_both();
      t_race();
      t_bank();
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #200000;
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=running expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule